// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of one SPI channel from the interface clock. While it is enabled it counts interface-clock cycles. Each time the count reaches the programmed ratio it raises a one-cycle half-period tick and flips the serial clock level. A shifter and a chip-select sequencer can then act on the tick. While it is disabled the counter is cleared and the serial clock rests at an idle level chosen by a polarity input.

The ratio comes from one of two granularities. Coarse mode divides by a power of two picked by a 4-bit code. Fine mode divides in single-cycle steps: a 4-bit code and an 8-bit extension form a 12-bit value, and that value plus one is the ratio. Ratio fields written while the divider runs are picked up only when the current half period ends, so a period in progress is never cut short or stretched.

Top module: `spi_clk_divider`

## Requirements
- R1: While reset (active low) is asserted, halfTick is 0 and sclk is 0.
- R2: At every clock edge where enable is sampled low, halfTick becomes 0 and sclk takes the value of idlePol.
- R3: With fineMode = 0, the ratio is 2 to the power divCode (1 to 32768). halfTick is high for one cycle in every ratio cycles.
- R4: With fineMode = 1, the ratio is {divExt, divCode} + 1, with divExt in bits 11:4 and divCode in bits 3:0 (1 to 4096). halfTick is high for one cycle in every ratio cycles.
- R5: After enable rises, the first halfTick follows the edge on which enable has been sampled high for the ratio-th time.
- R6: sclk inverts on every edge that raises halfTick. While enabled it holds its value on every other edge, so one serial clock period lasts twice the ratio.
- R7: A ratio of 1 (coarse code 0, or fine value 0) gives halfTick high on every enabled cycle.
- R8: A change of fineMode, divCode or divExt made while enabled does not alter the current half period. It governs the periods that follow the next halfTick.
- R9: Dropping enable for one cycle clears the count. After re-enabling, the next tick again comes a full ratio after restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the divider |
| fineMode | input | 1 | 0: power-of-two ratio, 1: single-step ratio |
| divCode | input | 4 | Exponent (coarse) or low ratio bits (fine) |
| divExt | input | 8 | High ratio bits in fine mode |
| idlePol | input | 1 | Serial clock level while disabled |
| halfTick | output | 1 | One-cycle pulse at each half-period boundary |
| sclk | output | 1 | Serial clock level |

## Verification
The hardest situation to reach is a ratio field change that lands in the middle of a running half period. The port-level evidence appears only one full period later. The bench switches from a coarse ratio of 4 to a fine ratio of 7 on the cycle just after a tick. It then expects one more tick at the old spacing before the new spacing begins. The bench also reaches the extreme ratios, 32768 and 4096, by running only two half periods of each. Random configurations are kept small enough that several ticks fit in the run.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic hold;  // disabled: clear and idle
    logic wrap;  // half-period boundary reached
  } divStrobes_t;
endpackage

// File: rtl/spi_div_ctrl.sv
module spi_div_ctrl
  import spi_div_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int EXT_W  = 8,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              fineMode,
  input  logic [CODE_W-1:0] divCode,
  input  logic [EXT_W-1:0]  divExt,
  input  logic [CNT_W-1:0]  cnt,
  output divStrobes_t       strobes,
  output logic [CNT_W-1:0]  limit
);
  localparam int FINE_W = CODE_W + EXT_W;

  logic [CNT_W-1:0] coarseLimit;
  logic [CNT_W-1:0] fineLimit;
  logic [CNT_W-1:0] nextLimit;
  logic [CNT_W-1:0] limitQ;

  always_comb begin
    coarseLimit = (CNT_W'(1) << divCode) - CNT_W'(1);
    fineLimit   = CNT_W'({divExt, divCode});
    nextLimit   = fineMode ? fineLimit : coarseLimit;
  end

  always_comb begin
    strobes.hold = !enable;
    strobes.wrap = enable && (cnt == limitQ);
  end

  // ratio is taken only when idle or at a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ <= '0;
    end else if (strobes.hold || strobes.wrap) begin
      limitQ <= nextLimit;
    end
  end

  assign limit = limitQ;

  if (FINE_W > CNT_W) begin : g_badWidth
    initial $error("counter narrower than fine ratio");
  end
endmodule

// File: rtl/spi_div_datapath.sv
module spi_div_datapath
  import spi_div_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic             idlePol,
  output logic [CNT_W-1:0] cnt,
  output logic             halfTick,
  output logic             sclk
);
  logic [CNT_W-1:0] cntQ;
  logic             tickQ;
  logic             sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      tickQ <= 1'b0;
      sclkQ <= 1'b0;
    end else if (strobes.hold) begin
      cntQ  <= '0;
      tickQ <= 1'b0;
      sclkQ <= idlePol;
    end else if (strobes.wrap) begin
      cntQ  <= '0;
      tickQ <= 1'b1;
      sclkQ <= ~sclkQ;
    end else begin
      cntQ  <= cntQ + CNT_W'(1);
      tickQ <= 1'b0;
    end
  end

  assign cnt      = cntQ;
  assign halfTick = tickQ;
  assign sclk     = sclkQ;
endmodule

// File: rtl/spi_clk_divider.sv
module spi_clk_divider
  import spi_div_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              fineMode,
  input  logic [CODE_W-1:0] divCode,
  input  logic [EXT_W-1:0]  divExt,
  input  logic              idlePol,
  output logic              halfTick,
  output logic              sclk
);
  localparam int COARSE_W = (2 ** CODE_W) - 1;
  localparam int FINE_W   = CODE_W + EXT_W;
  localparam int CNT_W    = (COARSE_W > FINE_W) ? COARSE_W : FINE_W;

  divStrobes_t      strobes;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limitQ;

  spi_div_ctrl #(
    .CODE_W(CODE_W),
    .EXT_W (EXT_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .fineMode(fineMode),
    .divCode (divCode),
    .divExt  (divExt),
    .cnt     (cntQ),
    .strobes (strobes),
    .limit   (limitQ)
  );

  spi_div_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .idlePol (idlePol),
    .cnt     (cntQ),
    .halfTick(halfTick),
    .sclk    (sclk)
  );
endmodule

// File: rtl/spi_div_checker.sv
module spi_div_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             idlePol,
  input logic             halfTick,
  input logic             sclk,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit
);
  assert_no_tick_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !halfTick);

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclk == $past(idlePol)));

  assert_toggle_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> (sclk != $past(sclk)));

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !halfTick) |-> $stable(sclk));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit);

  assert_count_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cnt == '0));
endmodule

bind spi_clk_divider spi_div_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .idlePol (idlePol),
  .halfTick(halfTick),
  .sclk    (sclk),
  .cnt     (cntQ),
  .limit   (limitQ)
);

// File: tb/spi_clk_divider_test.sv
module spi_clk_divider_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       fineMode = 1'b0;
  logic [3:0] divCode = '0;
  logic [7:0] divExt = '0;
  logic       idlePol = 1'b0;
  logic       halfTick;
  logic       sclk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  spi_clk_divider uut (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .fineMode(fineMode),
    .divCode (divCode),
    .divExt  (divExt),
    .idlePol (idlePol),
    .halfTick(halfTick),
    .sclk    (sclk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int expRatio(input logic fm, input logic [3:0] code, input logic [7:0] ext);
    if (fm) return int'({ext, code}) + 1;
    return 1 << code;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // disable, configure, then run nTicks half periods; tick and level compared every cycle
  task automatic runPattern(input logic fm, input logic [3:0] code, input logic [7:0] ext,
                            input logic pol, input int nTicks, input string req);
    int r = expRatio(fm, code, ext);
    int tickErr = 0;
    int lvlErr = 0;
    int firstTick = 0;
    logic level = pol;
    enable = 1'b0;
    fineMode = fm;
    divCode = code;
    divExt = ext;
    idlePol = pol;
    @(negedge clk);
    @(negedge clk);
    check(sclk === pol && halfTick === 1'b0, "R2 idle level", int'(sclk), int'(pol));
    enable = 1'b1;
    for (int cyc = 1; cyc <= nTicks * r; cyc++) begin
      bit expTick;
      @(negedge clk);
      expTick = (cyc % r) == 0;
      if (expTick) level = ~level;
      if (halfTick === 1'b1 && firstTick == 0) firstTick = cyc;
      if (halfTick !== expTick) tickErr++;
      if (sclk !== level) lvlErr++;
    end
    check(tickErr == 0, req, tickErr, 0);
    check(firstTick == r, "R5 first tick", firstTick, r);
    check(lvlErr == 0, "R6 sclk toggling", lvlErr, 0);
    enable = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    check(halfTick === 1'b0 && sclk === 1'b0, "R1 reset state", int'(sclk), 0);
    @(negedge clk);
    rstN = 1'b1;

    runPattern(1'b0, 4'd0, 8'd0, 1'b0, 6, "R7 coarse ratio 1");
    runPattern(1'b1, 4'd0, 8'd0, 1'b1, 6, "R7 fine ratio 1");
    runPattern(1'b0, 4'd3, 8'h5A, 1'b1, 4, "R3 coarse ratio 8");
    runPattern(1'b1, 4'd2, 8'd1, 1'b0, 4, "R4 fine ratio 19");
    runPattern(1'b1, 4'hF, 8'hFF, 1'b0, 2, "R4 fine max 4096");
    runPattern(1'b0, 4'hF, 8'd0, 1'b1, 2, "R3 coarse max 32768");

    // R8: coarse ratio 4, switched to fine ratio 7 just after the first tick
    begin
      int errs = 0;
      enable = 1'b0;
      fineMode = 1'b0;
      divCode = 4'd2;
      divExt = 8'd0;
      idlePol = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      for (int cyc = 1; cyc <= 22; cyc++) begin
        bit expTick;
        @(negedge clk);
        expTick = (cyc == 4) || (cyc == 8) || (cyc == 15) || (cyc == 22);
        if (halfTick !== expTick) errs++;
        if (cyc == 4) begin
          fineMode = 1'b1;
          divCode = 4'd6;
        end
      end
      check(errs == 0, "R8 deferred ratio change", errs, 0);
      enable = 1'b0;
    end

    // R9: restart after a one-cycle disable
    begin
      int errs = 0;
      fineMode = 1'b0;
      divCode = 4'd3;
      idlePol = 1'b1;
      @(negedge clk);
      enable = 1'b1;
      repeat (5) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(halfTick === 1'b0 && sclk === 1'b1, "R2 idle on short disable", int'(sclk), 1);
      enable = 1'b1;
      for (int cyc = 1; cyc <= 8; cyc++) begin
        @(negedge clk);
        if (halfTick !== (cyc == 8)) errs++;
      end
      check(errs == 0, "R9 restart from zero", errs, 0);
      enable = 1'b0;
    end

    // random configurations
    for (int i = 0; i < 10; i++) begin
      logic fm = 1'($urandom_range(0, 1));
      logic [3:0] code = fm ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 9));
      logic [7:0] ext = fm ? 8'($urandom_range(0, 47)) : 8'($urandom_range(0, 255));
      logic pol = 1'($urandom_range(0, 1));
      runPattern(fm, code, ext, pol, 3, fm ? "R4 random fine" : "R3 random coarse");
    end

    finishRun();
  end
endmodule